// File: doc/BRIEF.md
# Multi-Mode 16-Bit PWM Timer

This block is a 16-bit counter that steps once for every cycle on which its single-cycle `tick` input is high. A 4-bit mode field selects one of fifteen counting schemes, plus one reserved code. Plain modes count up and wrap. Fast PWM modes count up to a TOP value and restart from zero. Phase-correct modes, and the phase-and-frequency-correct variants, count up to TOP and back down. TOP is a fixed constant, the active value of compare register A, or the externally supplied `cap_top` value, depending on the mode.

Two compare channels, A and B, each hold a buffered compare value and drive one waveform output. Each channel's 2-bit output code and the current count direction decide what a match does to the output. Three sticky flags report overflow, match A and match B. An interrupt request line is raised for each flag whose enable bit is set.

Software reaches the block through a plain write port. The port is accepted on every cycle where `wr_en` is high and has no back-pressure. The block has no streaming data path, so no valid/ready pair is used. Control and status pins are plain levels.

Top module: `mm_pwm_timer`

## Requirements
- R1: After reset the count, the compare buffers, both waveforms, the flags and the interrupt requests are all zero.
- R2: The mode sets the counting scheme and TOP, and a counter write takes priority over a tick in the same cycle.
  - Plain modes 0, 4 and 12 count up from TOP to 0. Mode 0 uses TOP 0xFFFF, mode 4 uses compare A and mode 12 uses `cap_top`.
  - Fast modes 5, 6, 7, 14 and 15 count up from TOP to 0. They use TOP 0x00FF, 0x01FF, 0x03FF, `cap_top` and compare A respectively.
  - Mode 13 is reserved: the count holds and no event occurs.
- R3: The dual-slope modes turn from up to down at TOP and from down to up at zero, without repeating either endpoint.
  - Phase-correct modes are 1, 2, 3, 10 and 11, with TOP 0x00FF, 0x01FF, 0x03FF, `cap_top` and compare A.
  - Phase-and-frequency-correct modes are 8 and 9, with TOP `cap_top` and compare A.
- R4: A compare write takes effect at once in plain modes. In phase-correct modes it moves from the buffer to the active value on a tick taken at TOP. In fast and phase-and-frequency-correct modes it moves on a tick taken at zero.
- R5: The overflow flag (bit 0) is set on a tick taken in one of these states:
  - at 0xFFFF in plain modes;
  - at TOP in fast modes;
  - at zero while counting down in the dual-slope modes.
- R6: In plain modes a channel match applies its output code: 00 leaves the output unchanged, 01 toggles it, 10 clears it, 11 sets it.
- R7: In fast modes, code 10 clears the output on a match and sets it on the tick that wraps TOP to zero. Code 11 does the opposite. Code 01 toggles output A on a match only when mode bit 3 is set; otherwise code 01 does nothing, and it never does anything for B.
- R8: In dual-slope modes, code 10 clears the output on a match while counting up and sets it on a match while counting down. Code 11 does the opposite. Code 01 behaves as in R7.
- R9: In fast modes, a match whose active compare value equals TOP leaves the output unchanged when the code's high bit is set. The wrap action still occurs.
- R10: A tick taken while the count equals a channel's active compare value sets that channel's match flag (A bit 1, B bit 2), visible on the following cycle.
- R11: A force strobe applies the channel's output code in plain modes only. It sets no flag and leaves the count unchanged. In other modes it has no effect.
- R12: A counter write suppresses the match on both channels for the next tick.
- R13: Flags are cleared by writing ones to address 5 or by pulsing `irq_ack`, and a set in the same cycle wins over a clear. `irq` equals the flags ANDed with the enables.
- R14: Write address map:
  - address 0 is control: mode in bits 3:0, code A in bits 5:4, code B in bits 7:6, interrupt enables in bits 10:8 in flag order;
  - address 1 loads the count;
  - address 2 writes compare A and address 3 writes compare B;
  - address 4 is the force strobe, with bit 0 for A and bit 1 for B;
  - address 5 clears flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cap_top | input | 16 | Externally supplied TOP value |
| irq_ack | input | 3 | Per-flag interrupt acknowledge |
| count | output | 16 | Current count |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flags | output | 3 | Overflow, match A, match B flags |
| irq | output | 3 | Interrupt requests |

## Verification
The bench builds the block with the default width of 16. At that width all the fixed TOP constants can be reached, along with the 0xFFFF wrap point of mode 0, and the bench reaches that point by loading the counter just below it. Random segments keep `cap_top` and the compare values small, so that every mode completes many periods with buffer transfers, direction reversals and wraps. Directed cases cover the following:
- the dual-slope turn-around;
- the suppressed match after a counter write;
- the ignored match at TOP in fast mode;
- force strobes in plain and PWM modes;
- the reserved mode holding its count.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    FAM_PLAIN = 2'd0,
    FAM_FAST  = 2'd1,
    FAM_PC    = 2'd2,
    FAM_PFC   = 2'd3
  } fam_e;

  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_CMPA  = 2'd1,
    SRC_CAP   = 2'd2
  } src_e;

  typedef struct packed {
    fam_e fam;
    src_e src;
    logic hold;
  } mode_info_t;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_CNT   = 3'd1;
  localparam logic [2:0] ADR_CMPA  = 3'd2;
  localparam logic [2:0] ADR_CMPB  = 3'd3;
  localparam logic [2:0] ADR_FORCE = 3'd4;
  localparam logic [2:0] ADR_FCLR  = 3'd5;
  localparam int         NFLAG     = 3;

  function automatic mode_info_t decode_mode(input logic [3:0] m);
    mode_info_t r;
    r.fam  = FAM_PLAIN;
    r.src  = SRC_FIXED;
    r.hold = 1'b0;
    case (m)
      4'd1, 4'd2, 4'd3: r.fam = FAM_PC;
      4'd4:             r.src = SRC_CMPA;
      4'd5, 4'd6, 4'd7: r.fam = FAM_FAST;
      4'd8:  begin r.fam = FAM_PFC;  r.src = SRC_CAP;  end
      4'd9:  begin r.fam = FAM_PFC;  r.src = SRC_CMPA; end
      4'd10: begin r.fam = FAM_PC;   r.src = SRC_CAP;  end
      4'd11: begin r.fam = FAM_PC;   r.src = SRC_CMPA; end
      4'd12: r.src = SRC_CAP;
      4'd13: r.hold = 1'b1;
      4'd14: begin r.fam = FAM_FAST; r.src = SRC_CAP;  end
      4'd15: begin r.fam = FAM_FAST; r.src = SRC_CMPA; end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mmt_mode_decode.sv
module mmt_mode_decode
  import mmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] cmpa,
  input  logic [W-1:0] cap,
  output mode_info_t   info,
  output logic [W-1:0] top
);
  localparam int BASE_BITS = 7;

  logic [W-1:0] fixed_top;

  always_comb begin
    info = decode_mode(mode);
    if (mode[1:0] == 2'd0)
      fixed_top = '1;
    else
      fixed_top = W'((32'd1 << (32'(mode[1:0]) + 32'(BASE_BITS))) - 32'd1);
    case (info.src)
      SRC_CMPA: top = cmpa;
      SRC_CAP:  top = cap;
      default:  top = fixed_top;
    endcase
  end
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dual,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      if (!dual) down <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (step) begin
        if (!dual) begin
          cnt <= (cnt == top) ? '0 : cnt + ONE;
        end else if (!down) begin
          if (cnt == top) begin
            down <= 1'b1;
            cnt  <= (top == '0) ? '0 : cnt - ONE;
          end else begin
            cnt <= cnt + ONE;
          end
        end else begin
          if (cnt == '0) begin
            down <= 1'b0;
            cnt  <= (top == '0) ? '0 : ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mmt_channel.sv
module mmt_channel
  import mmt_pkg::*;
#(
  parameter int W         = 16,
  parameter bit TOGGLE_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fam_e         fam,
  input  logic         mode_msb,
  input  logic [1:0]   code,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_val,
  input  logic         upd,
  input  logic         step,
  input  logic         blk,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [W-1:0] top,
  input  logic         wrap,
  input  logic         force_i,
  output logic [W-1:0] act,
  output logic         match,
  output logic         wave
);
  logic [W-1:0] cmp_buf_q, act_q;
  logic         wave_q, wave_nx, tog_en;

  assign match  = step && !blk && (cnt == act_q);
  assign tog_en = TOGGLE_OK && mode_msb;
  assign act    = act_q;
  assign wave   = wave_q;

  always_comb begin
    wave_nx = wave_q;
    case (fam)
      FAM_PLAIN: begin
        if (match || force_i) begin
          case (code)
            2'b01:   wave_nx = ~wave_q;
            2'b10:   wave_nx = 1'b0;
            2'b11:   wave_nx = 1'b1;
            default: ;
          endcase
        end
      end
      FAM_FAST: begin
        if (wrap && code[1]) wave_nx = ~code[0];
        if (match && !(code[1] && act_q == top)) begin
          if (code[1])                wave_nx = code[0];
          else if (code[0] && tog_en) wave_nx = ~wave_q;
        end
      end
      default: begin
        if (match) begin
          if (code[1])                wave_nx = code[0] ^ down;
          else if (code[0] && tog_en) wave_nx = ~wave_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf_q <= '0;
      act_q     <= '0;
      wave_q    <= 1'b0;
    end else begin
      wave_q <= wave_nx;
      if (wr_cmp) cmp_buf_q <= wr_val;
      if (wr_cmp && fam == FAM_PLAIN) act_q <= wr_val;
      else if (upd)                   act_q <= cmp_buf_q;
    end
  end
endmodule

// File: rtl/mm_pwm_timer.sv
module mm_pwm_timer
  import mmt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cap_top,
  input  logic [2:0]   irq_ack,
  output logic [W-1:0] count,
  output logic         wave_a,
  output logic         wave_b,
  output logic [2:0]   flags,
  output logic [2:0]   irq
);
  localparam int NCH = 2;

  logic [3:0]       mode_q;
  logic [1:0]       code_q [NCH];
  logic [NFLAG-1:0] en_q, flags_q, flag_set, flag_clr;
  logic             blk_q;

  mode_info_t       info;
  logic [W-1:0]     top, cnt;
  logic             down, dual;
  logic [W-1:0]     act [NCH];
  logic [NCH-1:0]   match, wave;

  logic ctrl_wr, cnt_wr, frc_wr, fclr_wr;
  logic tick_eff, at_top, at_bot, ovf, upd, wrap;

  assign ctrl_wr  = wr_en && wr_addr == ADR_CTRL;
  assign cnt_wr   = wr_en && wr_addr == ADR_CNT;
  assign frc_wr   = wr_en && wr_addr == ADR_FORCE && info.fam == FAM_PLAIN;
  assign fclr_wr  = wr_en && wr_addr == ADR_FCLR;

  assign dual     = info.fam == FAM_PC || info.fam == FAM_PFC;
  assign tick_eff = tick && !info.hold && !cnt_wr;
  assign at_top   = cnt == top;
  assign at_bot   = cnt == '0;

  always_comb begin
    case (info.fam)
      FAM_PLAIN: ovf = tick_eff && (cnt == '1);
      FAM_FAST:  ovf = tick_eff && at_top;
      default:   ovf = tick_eff && down && at_bot;
    endcase
    case (info.fam)
      FAM_PLAIN: upd = 1'b0;
      FAM_PC:    upd = tick_eff && at_top;
      default:   upd = tick_eff && at_bot;
    endcase
  end
  assign wrap = tick_eff && info.fam == FAM_FAST && at_top;

  mmt_mode_decode #(.W(W)) u_dec (
    .mode (mode_q),
    .cmpa (act[0]),
    .cap  (cap_top),
    .info (info),
    .top  (top)
  );

  mmt_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tick_eff),
    .load     (cnt_wr),
    .load_val (wr_data),
    .dual     (dual),
    .top      (top),
    .cnt      (cnt),
    .down     (down)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    mmt_channel #(.W(W), .TOGGLE_OK(g == 0)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .fam      (info.fam),
      .mode_msb (mode_q[3]),
      .code     (code_q[g]),
      .wr_cmp   (wr_en && wr_addr == (ADR_CMPA + 3'(g))),
      .wr_val   (wr_data),
      .upd      (upd),
      .step     (tick_eff),
      .blk      (blk_q),
      .cnt      (cnt),
      .down     (down),
      .top      (top),
      .wrap     (wrap),
      .force_i  (frc_wr && wr_data[g]),
      .act      (act[g]),
      .match    (match[g]),
      .wave     (wave[g])
    );
  end

  assign flag_set = {match[1], match[0], ovf};
  assign flag_clr = (fclr_wr ? wr_data[NFLAG-1:0] : '0) | irq_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      code_q[0] <= '0;
      code_q[1] <= '0;
      en_q      <= '0;
      flags_q   <= '0;
      blk_q     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q    <= wr_data[3:0];
        code_q[0] <= wr_data[5:4];
        code_q[1] <= wr_data[7:6];
        en_q      <= wr_data[10:8];
      end
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      if (cnt_wr)        blk_q <= 1'b1;
      else if (tick_eff) blk_q <= 1'b0;
    end
  end

  assign count  = cnt;
  assign wave_a = wave[0];
  assign wave_b = wave[1];
  assign flags  = flags_q;
  assign irq    = flags_q & en_q;
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker
  import mmt_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [2:0]   irq_ack,
  input logic [W-1:0] count,
  input logic         wave_a,
  input logic         wave_b,
  input logic [2:0]   flags,
  input logic [3:0]   mode
);
  logic       cw, fw, dual_m, pend;
  logic [2:0] clr;

  assign cw     = wr_en && wr_addr == ADR_CNT;
  assign fw     = wr_en && wr_addr == ADR_FORCE;
  assign clr    = ((wr_en && wr_addr == ADR_FCLR) ? wr_data[2:0] : 3'b0) | irq_ack;
  assign dual_m = (mode >= 4'd1 && mode <= 4'd3) || (mode >= 4'd8 && mode <= 4'd11);

  always_ff @(posedge clk) begin
    if (!rst_n)    pend <= 1'b0;
    else if (cw)   pend <= 1'b1;
    else if (tick) pend <= 1'b0;
  end

  assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cw) |=> $stable(count));

  assert_reserved_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd13 && !cw) |=> $stable(count));

  assert_dual_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_m && tick && !cw && count != '0) |=> (count != $past(count)));

  assert_no_flag_without_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((flags & ~$past(flags)) == 3'b000));

  assert_flag_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == 3'b000));

  assert_wave_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !fw) |=> ($stable(wave_a) && $stable(wave_b)));

  assert_write_blocks_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && tick && !cw) |=> (((flags & ~$past(flags)) & 3'b110) == 3'b000));
endmodule

bind mm_pwm_timer mmt_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .irq_ack (irq_ack),
  .count   (count),
  .wave_a  (wave_a),
  .wave_b  (wave_b),
  .flags   (flags),
  .mode    (mode_q)
);

// File: tb/tb_mm_pwm_timer.sv
`timescale 1ns/1ps
module tb_mm_pwm_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cap_top = 16'd20;
  logic [2:0]   irq_ack = '0;
  logic [W-1:0] count;
  logic         wave_a, wave_b;
  logic [2:0]   flags, irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mm_pwm_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_top(cap_top), .irq_ack(irq_ack), .count(count),
    .wave_a(wave_a), .wave_b(wave_b), .flags(flags), .irq(irq)
  );

  // ---------------- reference model built from the requirements ----------------
  logic [3:0]   m_mode;
  logic [1:0]   m_code [2];
  logic [2:0]   m_en, m_fl;
  logic [W-1:0] m_cnt;
  logic         m_dn, m_blk;
  logic [W-1:0] m_buf [2];
  logic [W-1:0] m_act [2];
  logic         m_wv [2];

  function automatic int fam_of(logic [3:0] m);
    if (m inside {4'd1, 4'd2, 4'd3, 4'd10, 4'd11}) return 2;
    if (m inside {4'd8, 4'd9})                     return 3;
    if (m inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15}) return 1;
    return 0;
  endfunction

  function automatic logic [W-1:0] top_of(logic [3:0] m, logic [W-1:0] a, logic [W-1:0] c);
    if (m inside {4'd4, 4'd9, 4'd11, 4'd15}) return a;
    if (m inside {4'd8, 4'd10, 4'd12, 4'd14}) return c;
    if (m inside {4'd1, 4'd5}) return 16'h00FF;
    if (m inside {4'd2, 4'd6}) return 16'h01FF;
    if (m inside {4'd3, 4'd7}) return 16'h03FF;
    return 16'hFFFF;
  endfunction

  function automatic bit wave_next(int fam, bit [1:0] code, bit tog_ok, bit cur,
                                   bit mt, bit fc, bit wrp, bit dn, bit cmp_top);
    bit r = cur;
    case (fam)
      0: if (mt || fc) begin
           if (code == 2'd1) r = !cur;
           else if (code == 2'd2) r = 1'b0;
           else if (code == 2'd3) r = 1'b1;
         end
      1: begin
           if (wrp && code >= 2'd2) r = (code == 2'd2);
           if (mt && !(code >= 2'd2 && cmp_top)) begin
             if (code == 2'd2) r = 1'b0;
             else if (code == 2'd3) r = 1'b1;
             else if (code == 2'd1 && tog_ok) r = !cur;
           end
         end
      default: if (mt) begin
           if (code == 2'd2) r = dn;
           else if (code == 2'd3) r = !dn;
           else if (code == 2'd1 && tog_ok) r = !cur;
         end
    endcase
    return r;
  endfunction

  task automatic model_reset();
    m_mode = '0; m_en = '0; m_fl = '0; m_cnt = '0; m_dn = 1'b0; m_blk = 1'b0;
    for (int i = 0; i < 2; i++) begin
      m_code[i] = '0; m_buf[i] = '0; m_act[i] = '0; m_wv[i] = 1'b0;
    end
  endtask

  task automatic model_step();
    int fam;
    logic [W-1:0] top;
    bit hold, cw, te, at_t, at_b, ovf, upd, wrp, dual;
    bit [1:0] mt, fc;
    fam  = fam_of(m_mode);
    hold = (m_mode == 4'd13);
    top  = top_of(m_mode, m_act[0], cap_top);
    dual = (fam >= 2);
    cw   = wr_en && wr_addr == 3'd1;
    te   = tick && !hold && !cw;
    at_t = (m_cnt == top);
    at_b = (m_cnt == 16'd0);
    for (int i = 0; i < 2; i++) begin
      mt[i] = te && !m_blk && (m_cnt == m_act[i]);
      fc[i] = wr_en && wr_addr == 3'd4 && wr_data[i];
    end
    ovf = te && ((fam == 0) ? (m_cnt == 16'hFFFF) : (fam == 1) ? at_t : (m_dn && at_b));
    upd = te && ((fam == 2) ? at_t : (fam != 0 && at_b));
    wrp = te && fam == 1 && at_t;
    for (int i = 0; i < 2; i++)
      m_wv[i] = wave_next(fam, m_code[i], (i == 0) && m_mode[3], m_wv[i], mt[i], fc[i],
                          wrp, m_dn, m_act[i] == top);
    for (int i = 0; i < 2; i++) begin
      if (wr_en && wr_addr == 3'(2 + i)) begin
        if (fam == 0) m_act[i] = wr_data;
        else if (upd) m_act[i] = m_buf[i];
        m_buf[i] = wr_data;
      end else if (upd) begin
        m_act[i] = m_buf[i];
      end
    end
    m_fl = (m_fl & ~((wr_en && wr_addr == 3'd5) ? wr_data[2:0] : 3'b0) & ~irq_ack)
           | {mt[1], mt[0], ovf};
    if (cw) m_blk = 1'b1; else if (te) m_blk = 1'b0;
    if (!dual) m_dn = 1'b0;
    if (cw) m_cnt = wr_data;
    else if (te) begin
      if (!dual) m_cnt = at_t ? 16'd0 : m_cnt + 16'd1;
      else if (!m_dn) begin
        if (at_t) begin m_dn = 1'b1; m_cnt = (top == 0) ? 16'd0 : m_cnt - 16'd1; end
        else m_cnt = m_cnt + 16'd1;
      end else begin
        if (at_b) begin m_dn = 1'b0; m_cnt = (top == 0) ? 16'd0 : 16'd1; end
        else m_cnt = m_cnt - 16'd1;
      end
    end
    if (wr_en && wr_addr == 3'd0) begin
      m_mode = wr_data[3:0]; m_code[0] = wr_data[5:4];
      m_code[1] = wr_data[7:6]; m_en = wr_data[10:8];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R3 count vs model", 32'(count), 32'(m_cnt));
      chk("R6 R7 R8 R9 waves vs model", {30'd0, wave_b, wave_a}, {30'd0, m_wv[1], m_wv[0]});
      chk("R4 R5 R10 R13 flags/irq vs model", {26'd0, irq, flags}, {26'd0, m_fl & m_en, m_fl});
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit t, input bit we, input logic [2:0] a,
                     input logic [W-1:0] d, input logic [2:0] ack);
    tick = t; wr_en = we; wr_addr = a; wr_data = d; irq_ack = ack;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; irq_ack = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc(1'b0, 1'b1, a, d, 3'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, '0, 3'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit all_high;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 32'd0);
    chk("R1 waves/flags/irq", {26'd0, wave_b, wave_a, flags, irq}, 32'd0);

    // R3 phase-correct 8-bit turn-around at TOP 0xFF
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'h00FD);
    ticks(3);
    chk("R3 turn at top", 32'(count), 32'h00FE);
    ticks(3);
    chk("R3 counting down", 32'(count), 32'h00FB);

    // R2 R5 plain mode wraps at 0xFFFF and sets overflow
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'hFFFE);
    ticks(2);
    chk("R2 wrap at max", 32'(count), 32'd0);
    chk("R5 overflow flag", 32'(flags), 32'b001);
    wr(3'd5, 16'h0001);
    chk("R13 write-one clear", 32'(flags), 32'b000);

    // R12 R6 R10: counter write blocks the next match
    wr(3'd0, 16'h0030);
    wr(3'd2, 16'd5);
    wr(3'd1, 16'd5);
    ticks(1);
    chk("R12 blocked match flag", 32'(flags), 32'b000);
    chk("R12 blocked match wave", 32'(wave_a), 32'd0);
    wr(3'd1, 16'd4);
    ticks(2);
    chk("R10 match flag A", 32'(flags), 32'b010);
    chk("R6 set on match", 32'(wave_a), 32'd1);

    // R13 R14 enables and acknowledge
    wr(3'd0, 16'h0230);
    chk("R13 R14 irq follows enable", 32'(irq), 32'b010);
    cyc(1'b0, 1'b0, 3'd0, '0, 3'b010);
    chk("R13 ack clears", {29'd0, irq}, {29'd0, 3'b000});
    chk("R13 ack clears flag", 32'(flags), 32'b000);

    // R11 force strobe
    wr(3'd0, 16'h0010);
    wr(3'd4, 16'h0001);
    chk("R11 force toggles", 32'(wave_a), 32'd0);
    chk("R11 force no flag, no count change", {13'd0, flags, count}, {13'd0, 3'b000, 16'd6});
    wr(3'd0, 16'h0035);
    wr(3'd4, 16'h0001);
    chk("R11 force ignored in fast mode", 32'(wave_a), 32'd0);

    // R9 fast mode with compare A as TOP: match ignored, wrap sets
    wr(3'd0, 16'h002F);
    wr(3'd2, 16'd20);
    wr(3'd1, 16'd0);
    ticks(25);
    all_high = 1'b1;
    for (int i = 0; i < 22; i++) begin
      ticks(1);
      if (wave_a !== 1'b1) all_high = 1'b0;
    end
    chk("R9 R7 output held high at TOP compare", 32'(all_high), 32'd1);

    // R2 reserved mode holds
    wr(3'd0, 16'h000D);
    wr(3'd1, 16'd7);
    ticks(5);
    chk("R2 reserved mode holds count", 32'(count), 32'd7);

    // random segments, checked against the model every cycle
    for (int s = 0; s < 16; s++) begin
      cap_top = 16'(8 + $urandom % 50);
      wr(3'd2, 16'($urandom % 64));
      wr(3'd3, 16'($urandom % 64));
      wr(3'd0, 16'($urandom % 2048));
      wr(3'd1, 16'd0);
      for (int c = 0; c < 4000; c++) begin
        int r;
        r = $urandom % 64;
        if (r == 0)
          cyc(1'b0, 1'b1, 3'(2 + $urandom % 4), 16'($urandom % 64), 3'b0);
        else if (r == 1)
          cyc(1'b1, 1'b0, 3'd0, '0, 3'($urandom % 8));
        else
          cyc(($urandom % 3) != 0, 1'b0, 3'd0, '0, 3'b0);
      end
    end
    finish_run();
  end
endmodule